// File: doc/BRIEF.md
# Sequential-Access Address Generator

This block is the address stage of a small 32-bit processor. It keeps the current bus address in an address register of its own, and an incrementer is attached to that register rather than to the program counter. Each time the memory system completes an access, the register either advances by one word or takes a newly requested address. A one-bit hint tells an external memory controller whether the current access directly follows the previous one. When it does, the controller can leave a DRAM page open and run a short cycle.

Address loads arrive on a valid/ready channel. A load comes from the program counter, a branch target or a data address. The channel's ready equals the bus-advance strobe, so a held load simply waits until the current access completes. A loaded access is always non-sequential. Accesses that come from the incrementer are sequential, including the later beats of a block transfer.

While the incrementer is fetching instructions, the next address is sent to the program counter in the same cycle. This lets the register file update the PC early. During a block transfer the incremented addresses belong to data, so no PC update is issued. The PC update port has no back-pressure: the register file must accept every valid beat.

Top module: `seq_addr_gen`

## Requirements
- R1: During reset and in the first cycle after it, `bus_addr` equals RESET_ADDR (default 0) and `seq_hint` is 0, so the first access is non-sequential.
- R2: In a cycle where `advance` is 0, neither `bus_addr` nor `seq_hint` changes at the next clock edge, whatever `ld_valid`, `ld_addr` and `blk_mode` are.
- R3: On a clock edge with `advance` 1 and `ld_valid` 0, `bus_addr` becomes the previous `bus_addr` plus 4 and `seq_hint` becomes 1.
- R4: On a clock edge with `advance` 1 and `ld_valid` 1, `bus_addr` becomes `ld_addr` with bits [1:0] forced to 0, and `seq_hint` becomes 0.
- R5: `ld_ready` equals `advance` in every cycle, so a load is consumed only when the current access completes.
- R6: When `advance` is 1, `ld_valid` is 0 and `blk_mode` is 0, `pc_wr_valid` is 1 in that same cycle and `pc_wr_data` equals `bus_addr` plus 4. In all other cycles `pc_wr_valid` is 0.
- R7: While `blk_mode` is 1, `pc_wr_valid` stays 0, and block beats after the first still step by 4 with `seq_hint` set to 1.
- R8: Bits [1:0] of `bus_addr` are always 0.
- R9: Stepping from address 0xFFFFFFFC wraps to 0x00000000, and that step still counts as sequential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A new address is offered for the next access |
| ld_ready | output | 1 | The offered address is taken at this edge (equals `advance`) |
| ld_addr | input | 32 | Byte address offered for loading |
| blk_mode | input | 1 | A block transfer is in progress, so the incremented address is not a PC value |
| advance | input | 1 | The current bus access completes at this edge |
| bus_addr | output | 32 | Address of the current access |
| seq_hint | output | 1 | 1 when the current access is one word after the previous one |
| pc_wr_valid | output | 1 | Write the next fetch address into the program counter |
| pc_wr_data | output | 32 | Next fetch address for the program counter |

## Verification
The assertions check on every cycle that the address holds while the strobe is low. They also check the word step and the sequential flag after an unloaded advance, the alignment and the cleared flag after a load, the zero low bits, and the bypass relation and block-mode suppression on the PC port. Only the bench's scenarios can show the reset value and the first access after reset. The bench also covers the wrap at the top of the address space, a load held through several stretched cycles before it is taken, and a full block burst that is entered by a load and left by a branch.

// File: rtl/seqag_pkg.sv
package seqag_pkg;
  // Classification of the access currently on the bus.
  typedef enum logic {
    ACC_NONSEQ = 1'b0,
    ACC_SEQ    = 1'b1
  } acc_kind_e;

  localparam int unsigned DEF_ADDR_W     = 32;
  localparam int unsigned DEF_WORD_BYTES = 4;
endpackage

// File: rtl/seqag_addr_reg.sv
module seqag_addr_reg #(
  parameter int unsigned AW         = seqag_pkg::DEF_ADDR_W,
  parameter int unsigned WORD_BYTES = seqag_pkg::DEF_WORD_BYTES,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          load_en,
  input  logic [AW-1:0] load_addr,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] inc_addr
);
  localparam logic [AW-1:0] STEP       = AW'(WORD_BYTES);
  localparam logic [AW-1:0] ALIGN_MASK = ~(AW'(WORD_BYTES - 1));

  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_d;

  // The incrementer belongs to the address register, not to the PC.
  assign inc_addr = addr_q + STEP;

  always_comb begin
    addr_d = addr_q;
    if (load_en)      addr_d = load_addr & ALIGN_MASK;
    else if (step_en) addr_d = inc_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) addr_q <= RESET_ADDR & ALIGN_MASK;
    else        addr_q <= addr_d;
  end

  assign cur_addr = addr_q;
endmodule

// File: rtl/seqag_seq_track.sv
module seqag_seq_track
  import seqag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  input  logic load_take,
  output logic seq_hint
);
  acc_kind_e kind_q;

  // Any explicit load forces a full cycle; an incrementer step is sequential.
  always_ff @(posedge clk) begin
    if (!rst_n)       kind_q <= ACC_NONSEQ;
    else if (advance) kind_q <= load_take ? ACC_NONSEQ : ACC_SEQ;
  end

  assign seq_hint = (kind_q == ACC_SEQ);
endmodule

// File: rtl/seqag_pc_wb.sv
module seqag_pc_wb #(
  parameter int unsigned AW = seqag_pkg::DEF_ADDR_W
) (
  input  logic          advance,
  input  logic          load_take,
  input  logic          blk_mode,
  input  logic [AW-1:0] inc_addr,
  output logic          pc_wr_valid,
  output logic [AW-1:0] pc_wr_data
);
  // The next fetch address is bypassed to the PC in the cycle it is formed.
  assign pc_wr_valid = advance & ~load_take & ~blk_mode;
  assign pc_wr_data  = inc_addr;
endmodule

// File: rtl/seq_addr_gen.sv
module seq_addr_gen #(
  parameter int unsigned AW         = seqag_pkg::DEF_ADDR_W,
  parameter int unsigned WORD_BYTES = seqag_pkg::DEF_WORD_BYTES,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [AW-1:0] ld_addr,
  input  logic          blk_mode,
  input  logic          advance,
  output logic [AW-1:0] bus_addr,
  output logic          seq_hint,
  output logic          pc_wr_valid,
  output logic [AW-1:0] pc_wr_data
);
  logic          load_take;
  logic          step_take;
  logic [AW-1:0] inc_addr;

  assign ld_ready  = advance;
  assign load_take = ld_valid & advance;
  assign step_take = advance & ~ld_valid;

  seqag_addr_reg #(
    .AW(AW), .WORD_BYTES(WORD_BYTES), .RESET_ADDR(RESET_ADDR)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .step_en(step_take), .load_en(load_take),
    .load_addr(ld_addr), .cur_addr(bus_addr), .inc_addr(inc_addr)
  );

  seqag_seq_track u_seq (
    .clk(clk), .rst_n(rst_n), .advance(advance), .load_take(load_take),
    .seq_hint(seq_hint)
  );

  seqag_pc_wb #(.AW(AW)) u_pc (
    .advance(advance), .load_take(load_take), .blk_mode(blk_mode),
    .inc_addr(inc_addr), .pc_wr_valid(pc_wr_valid), .pc_wr_data(pc_wr_data)
  );
endmodule

// File: rtl/seq_addr_gen_chk.sv
module seq_addr_gen_chk #(
  parameter int unsigned AW         = 32,
  parameter int unsigned WORD_BYTES = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_valid,
  input logic [AW-1:0] ld_addr,
  input logic          blk_mode,
  input logic          advance,
  input logic [AW-1:0] bus_addr,
  input logic          seq_hint,
  input logic          pc_wr_valid,
  input logic [AW-1:0] pc_wr_data
);
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);
  localparam logic [AW-1:0] MASK = ~(AW'(WORD_BYTES - 1));
  localparam logic [AW-1:0] LOWB = AW'(WORD_BYTES - 1);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> ($stable(bus_addr) && $stable(seq_hint)));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !ld_valid) |=> (bus_addr == $past(bus_addr) + STEP) && seq_hint);

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && ld_valid) |=> (bus_addr == ($past(ld_addr) & MASK)) && !seq_hint);

  p_pc_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_valid |-> (pc_wr_data == bus_addr + STEP) && advance);

  p_blk_nopc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    blk_mode |-> !pc_wr_valid);

  p_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr & LOWB) == '0);
endmodule

bind seq_addr_gen seq_addr_gen_chk #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
  .blk_mode(blk_mode), .advance(advance), .bus_addr(bus_addr),
  .seq_hint(seq_hint), .pc_wr_valid(pc_wr_valid), .pc_wr_data(pc_wr_data)
);

// File: tb/seq_addr_gen_tb.sv
module seq_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [31:0] ld_addr = '0;
  logic        blk_mode = 1'b0;
  logic        advance = 1'b0;
  logic [31:0] bus_addr;
  logic        seq_hint;
  logic        pc_wr_valid;
  logic [31:0] pc_wr_data;

  int unsigned checks = 0;
  int unsigned errors = 0;
  logic        done = 1'b0;
  logic [31:0] exp_addr = '0;
  logic        exp_seq = 1'b0;

  always #2 clk = ~clk;

  seq_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .blk_mode(blk_mode), .advance(advance),
    .bus_addr(bus_addr), .seq_hint(seq_hint), .pc_wr_valid(pc_wr_valid),
    .pc_wr_data(pc_wr_data)
  );

  function automatic logic [31:0] f_align(input logic [31:0] a);
    return a & 32'hFFFF_FFFC;
  endfunction

  function automatic logic [31:0] f_next(input logic [31:0] a);
    return a + 32'd4;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // One bus cycle: drive at the falling edge, check the bypass path there,
  // then check the registered state just after the rising edge.
  task automatic cyc(input logic v, input logic [31:0] a, input logic blk, input logic adv);
    logic pc_exp;
    string rq;
    @(negedge clk);
    ld_valid = v; ld_addr = a; blk_mode = blk; advance = adv;
    #1;
    pc_exp = adv && !v && !blk;
    chk("R5", {31'd0, ld_ready}, {31'd0, adv});
    chk(blk ? "R7" : "R6", {31'd0, pc_wr_valid}, {31'd0, pc_exp});
    if (pc_exp) chk("R6", pc_wr_data, f_next(exp_addr));
    @(posedge clk);
    #1;
    if (!adv)   rq = "R2";
    else if (v) rq = "R4";
    else        rq = blk ? "R7" : "R3";
    if (adv) begin
      if (v) begin exp_addr = f_align(a); exp_seq = 1'b0; end
      else   begin exp_addr = f_next(exp_addr); exp_seq = 1'b1; end
    end
    chk(rq, bus_addr, exp_addr);
    chk(rq, {31'd0, seq_hint}, {31'd0, exp_seq});
    chk("R8", {30'd0, bus_addr[1:0]}, 32'd0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", bus_addr, 32'd0);
    chk("R1", {31'd0, seq_hint}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R1", bus_addr, 32'd0);
    chk("R1", {31'd0, seq_hint}, 32'd0);

    // First fetch steps become sequential.
    cyc(1'b0, '0, 1'b0, 1'b1);
    cyc(1'b0, '0, 1'b0, 1'b1);
    // Branch load offered while stretched: ignored until advance.
    cyc(1'b1, 32'h0000_1237, 1'b0, 1'b0);
    cyc(1'b1, 32'h0000_1237, 1'b0, 1'b0);
    cyc(1'b1, 32'h0000_1237, 1'b0, 1'b1);
    // Wrap at top of address space (R9).
    cyc(1'b1, 32'hFFFF_FFFE, 1'b0, 1'b1);
    cyc(1'b0, '0, 1'b0, 1'b1);
    chk("R9", bus_addr, 32'd0);
    chk("R9", {31'd0, seq_hint}, 32'd1);
    // Block burst: load then steps with PC update suppressed, left by a branch.
    cyc(1'b1, 32'h0000_8000, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) cyc(1'b0, '0, 1'b1, 1'b1);
    cyc(1'b0, '0, 1'b1, 1'b0);
    cyc(1'b1, 32'h0000_0040, 1'b0, 1'b1);

    // Constrained random mix.
    for (int n = 0; n < 3000; n++) begin
      logic v, blk, adv;
      logic [31:0] a;
      v   = ($urandom % 5) == 0;
      blk = ($urandom % 4) == 0;
      adv = ($urandom % 3) != 0;
      a   = $urandom;
      cyc(v, a, blk, adv);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule